// File: doc/BRIEF.md
# Descriptor Ring Receive DMA Channel

This block moves an incoming byte stream of framed packets into memory. Software describes the receive buffers with a ring of read-only, two-word descriptors and gives the channel a control word, a ring base and the pointer of the last posted descriptor. The channel fetches descriptors ahead of the data. It writes each frame byte by byte through a simple memory write port, starting a programmable number of bytes into the first buffer of every frame. A frame that outruns its buffer spills into the buffers of the following descriptors. Descriptors are never written back. Software learns how far the channel has got from the current-descriptor field of the status word alone, which advances past every buffer the channel uses.

A small internal FIFO absorbs the incoming bytes while a descriptor is fetched. When the channel catches up with the posted pointer it sits in idle wait and stalls the stream. Descriptor protocol errors, bus errors on either port and FIFO overflow halt the channel with an error code until the enable is dropped. A direct-FIFO mode bypasses the descriptors altogether: received bytes then stay in the FIFO and software reads them through a register port.

Top module: `rx_ring_dma`

## Requirements
- R1: While the enable bit (bit 0 of `rxCtrl`) is low, the next status word is all zero and `inReady`, `descRdReq` and `memWrEn` are low. Dropping the enable clears the pointers, the error code and the FIFO.
- R2: A descriptor is read as one 64-bit word at address `(ringBase & ~0xFFF) | curPtr`. Bits [12:0] hold the buffer byte count, bit 28 marks end of table and bits [63:32] hold the buffer address. After the buffer is used, the current pointer advances by 8, or returns to 0 when end of table was set.
- R3: The first byte of every frame is written at buffer address plus the frame offset, taken from `rxCtrl[7:1]`. Buffers that continue a frame are filled from offset 0.
- R4: A buffer receives at most byte-count bytes in total, counting the skipped offset. The frame then continues in the next descriptor's buffer, and the current pointer advances when a buffer fills or a frame ends.
- R5: When the current pointer equals `lastPtr`, the channel fetches nothing, reports idle wait and holds `inReady` low. It resumes once `lastPtr` moves.
- R6: The status word holds the current pointer in [11:0], the state in [15:12] (0 disabled, 1 active, 2 idle wait, 3 halted on error), the error code in [19:16] and the active descriptor in [31:20].
- R7: The active descriptor field holds the pointer of the most recently fetched descriptor.
- R8: A descriptor whose byte count does not exceed the start offset that applies to its buffer, or that has any control bit set outside [12:0] and bit 28, raises error 1.
- R9: A descriptor read that returns `descRdErr` raises error 4.
- R10: A memory write answered by `memWrErr` raises error 3, and no further write follows.
- R11: A byte accepted while the FIFO is full and not being drained raises error 2 and is dropped.
- R12: Any error sets state 3, and the error code then holds. While halted, `inReady`, `descRdReq` and `memWrEn` stay low until the enable drops.
- R13: With `rxCtrl[8]` set when the channel is enabled, no descriptor reads or memory writes occur. Bytes come out in order on `pioRdData` and `pioRdLast` when `pioRdEn` pops them, and `inReady` falls while the FIFO is full. Changing the mode bit while the channel is enabled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxCtrl | input | 9 | Enable [0], frame offset [7:1], direct-FIFO mode [8] |
| ringBase | input | 32 | Ring base; bits [11:0] ignored |
| lastPtr | input | 12 | Byte pointer of the last posted descriptor |
| statusWord | output | 32 | Current pointer, state, error code, active descriptor |
| inValid | input | 1 | Incoming byte valid |
| inData | input | 8 | Incoming byte |
| inLast | input | 1 | Byte ends a frame |
| inReady | output | 1 | Channel accepts a byte this cycle |
| descRdReq | output | 1 | Descriptor read request, held until answered |
| descRdAddr | output | 32 | Descriptor address |
| descRdValid | input | 1 | Descriptor read answer |
| descRdData | input | 64 | Descriptor word |
| descRdErr | input | 1 | Bus error on the descriptor read |
| memWrEn | output | 1 | Buffer byte write |
| memWrAddr | output | 32 | Buffer byte address |
| memWrData | output | 8 | Buffer byte |
| memWrErr | input | 1 | Bus error on this write, same cycle |
| pioRdEn | input | 1 | Pop one byte in direct-FIFO mode |
| pioRdValid | output | 1 | A byte is waiting in direct-FIFO mode |
| pioRdData | output | 8 | Head byte |
| pioRdLast | output | 1 | Head byte ends a frame |

## Verification
Some rules hold cycle by cycle, and the assertions check those on every cycle: the status word is all zero after the enable drops, idle wait and halt stall the stream and all traffic, direct-FIFO mode stays off both memory ports, an error code never changes while the channel stays enabled, and writes happen only while the channel reports itself active. Byte placement needs the bench's scenarios. That covers the frame offset on the first buffer only, spilling over buffers of differing sizes, wrap at end of table, and the pointer reached after each frame. Each error cause needs its own staged scenario too.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 32;
  localparam int BC_W    = 13;
  localparam int RPTR_W  = 12;
  localparam int OFF_W   = 7;
  localparam int EOT_BIT = 28;
  localparam logic [RPTR_W-1:0] DESC_STEP = RPTR_W'(8);
  localparam logic [31:0] DESC_USED_MASK = (32'h1 << EOT_BIT) | ((32'h1 << BC_W) - 32'h1);

  localparam logic [3:0] ERR_NONE    = 4'd0;
  localparam logic [3:0] ERR_DPE     = 4'd1;
  localparam logic [3:0] ERR_OVF     = 4'd2;
  localparam logic [3:0] ERR_WRBUS   = 4'd3;
  localparam logic [3:0] ERR_DESCBUS = 4'd4;

  localparam logic [3:0] STC_OFF    = 4'd0;
  localparam logic [3:0] STC_ACTIVE = 4'd1;
  localparam logic [3:0] STC_IDLE   = 4'd2;
  localparam logic [3:0] STC_HALT   = 4'd3;

  typedef enum logic [2:0] {
    S_OFF, S_POST, S_FETCH, S_FILL, S_PIO, S_HALT
  } rxState_e;

  typedef struct packed {
    logic              flush;
    logic              load;
    logic              pop;
    logic              acceptEn;
    logic [ADDR_W-1:0] loadBase;
    logic [BC_W-1:0]   loadStart;
    logic [BC_W-1:0]   loadLimit;
  } dpCmd_t;
endpackage

// File: rtl/rxdma_datapath.sv
module rxdma_datapath
  import rxdma_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inLast,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [BYTE_W-1:0] headData,
  output logic              headLast,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              lastSlot,
  output logic              overflowHit
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(FIFO_DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic [BYTE_W:0]     store [FIFO_DEPTH];
  logic [PTR_W-1:0]    rdPtr, wrPtr;
  logic [CNT_W-1:0]    fill;
  logic                accept, doPush, doPop;
  logic [ADDR_W-1:0]   bufBase;
  logic [BC_W-1:0]     wrIdx, wrLimit;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    fifoEmpty   = (fill == '0);
    fifoFull    = (fill == FULL_CNT);
    accept      = inValid && cmd.acceptEn;
    doPop       = cmd.pop && !fifoEmpty;
    doPush      = accept && (!fifoFull || doPop);
    overflowHit = accept && fifoFull && !doPop;
    headData    = store[rdPtr][BYTE_W-1:0];
    headLast    = store[rdPtr][BYTE_W];
    memWrAddr   = bufBase + ADDR_W'(wrIdx);
    lastSlot    = (BC_W'(wrIdx + BC_W'(1)) == wrLimit);
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= {inLast, inData};
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   fill <= fill + CNT_W'(1);
        2'b01:   fill <= fill - CNT_W'(1);
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufBase <= '0;
      wrIdx   <= '0;
      wrLimit <= '0;
    end else if (cmd.load) begin
      bufBase <= cmd.loadBase;
      wrIdx   <= cmd.loadStart;
      wrLimit <= cmd.loadLimit;
    end else if (doPop) begin
      wrIdx <= wrIdx + BC_W'(1);
    end
  end
endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
  import rxdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [8:0]        rxCtrl,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [RPTR_W-1:0] lastPtr,
  output logic [31:0]       statusWord,
  output logic              descRdReq,
  output logic [ADDR_W-1:0] descRdAddr,
  input  logic              descRdValid,
  input  logic [63:0]       descRdData,
  input  logic              descRdErr,
  output logic              memWrEn,
  input  logic              memWrErr,
  input  logic              pioRdEn,
  input  logic              fifoEmpty,
  input  logic              fifoFull,
  input  logic              headLast,
  input  logic              lastSlot,
  input  logic              overflowHit,
  output logic              pioActive,
  output dpCmd_t            cmd
);
  rxState_e          state;
  logic [RPTR_W-1:0] curPtr, actPtr;
  logic [3:0]        errCode, stateCode;
  logic              firstBuf, eotHeld;

  logic              cfgEnable, cfgPio;
  logic [OFF_W-1:0]  cfgOffset;
  logic [BC_W-1:0]   startOff, dCount;
  logic              dEot, dReserved, dBad, inRing, atLast;
  logic [ADDR_W-1:0] dAddr;

  always_comb begin
    cfgEnable = rxCtrl[0];
    cfgOffset = rxCtrl[OFF_W:1];
    cfgPio    = rxCtrl[8];
    startOff  = firstBuf ? BC_W'(cfgOffset) : '0;
    dCount    = descRdData[BC_W-1:0];
    dEot      = descRdData[EOT_BIT];
    dAddr     = descRdData[63:32];
    dReserved = (descRdData[31:0] & ~DESC_USED_MASK) != 32'h0;
    dBad      = dReserved || (dCount <= startOff);
    inRing    = (state == S_POST) || (state == S_FETCH) || (state == S_FILL);
    atLast    = (curPtr == lastPtr);
    pioActive = (state == S_PIO);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !cfgEnable) begin
      state    <= S_OFF;
      curPtr   <= '0;
      actPtr   <= '0;
      errCode  <= ERR_NONE;
      firstBuf <= 1'b1;
      eotHeld  <= 1'b0;
    end else begin
      case (state)
        S_OFF:  state <= cfgPio ? S_PIO : S_POST;
        S_POST: if (!atLast) state <= S_FETCH;
        S_FETCH: begin
          if (descRdValid) begin
            actPtr  <= curPtr;
            eotHeld <= dEot;
            if (descRdErr) begin
              errCode <= ERR_DESCBUS;
              state   <= S_HALT;
            end else if (dBad) begin
              errCode <= ERR_DPE;
              state   <= S_HALT;
            end else begin
              state <= S_FILL;
            end
          end
        end
        S_FILL: begin
          if (!fifoEmpty) begin
            if (memWrErr) begin
              errCode <= ERR_WRBUS;
              state   <= S_HALT;
            end else if (headLast || lastSlot) begin
              curPtr   <= eotHeld ? '0 : curPtr + DESC_STEP;
              firstBuf <= headLast;
              state    <= S_POST;
            end
          end
        end
        default: state <= state;
      endcase
      if (overflowHit && inRing) begin
        errCode <= ERR_OVF;
        state   <= S_HALT;
      end
    end
  end

  always_comb begin
    descRdReq  = (state == S_FETCH);
    descRdAddr = (ringBase & ~ADDR_W'(32'hFFF)) | ADDR_W'(curPtr);
    memWrEn    = (state == S_FILL) && !fifoEmpty;

    cmd           = '0;
    cmd.flush     = !cfgEnable;
    cmd.load      = descRdReq && descRdValid && !descRdErr;
    cmd.pop       = memWrEn || (pioActive && pioRdEn);
    cmd.loadBase  = dAddr;
    cmd.loadStart = startOff;
    cmd.loadLimit = dCount;
    case (state)
      S_POST:          cmd.acceptEn = !atLast;
      S_FETCH, S_FILL: cmd.acceptEn = 1'b1;
      S_PIO:           cmd.acceptEn = !fifoFull;
      default:         cmd.acceptEn = 1'b0;
    endcase

    case (state)
      S_OFF:   stateCode = STC_OFF;
      S_HALT:  stateCode = STC_HALT;
      S_POST:  stateCode = atLast ? STC_IDLE : STC_ACTIVE;
      default: stateCode = STC_ACTIVE;
    endcase
    statusWord = {actPtr, errCode, stateCode, curPtr};
  end
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rxdma_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [8:0]  rxCtrl,
  input  logic [31:0] ringBase,
  input  logic [11:0] lastPtr,
  output logic [31:0] statusWord,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  logic        inLast,
  output logic        inReady,
  output logic        descRdReq,
  output logic [31:0] descRdAddr,
  input  logic        descRdValid,
  input  logic [63:0] descRdData,
  input  logic        descRdErr,
  output logic        memWrEn,
  output logic [31:0] memWrAddr,
  output logic [7:0]  memWrData,
  input  logic        memWrErr,
  input  logic        pioRdEn,
  output logic        pioRdValid,
  output logic [7:0]  pioRdData,
  output logic        pioRdLast
);
  dpCmd_t      cmd;
  logic [7:0]  headData;
  logic        headLast, fifoEmpty, fifoFull, lastSlot, overflowHit, pioActive;

  rxdma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxCtrl(rxCtrl), .ringBase(ringBase), .lastPtr(lastPtr),
    .statusWord(statusWord), .descRdReq(descRdReq), .descRdAddr(descRdAddr),
    .descRdValid(descRdValid), .descRdData(descRdData), .descRdErr(descRdErr),
    .memWrEn(memWrEn), .memWrErr(memWrErr), .pioRdEn(pioRdEn),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .headLast(headLast),
    .lastSlot(lastSlot), .overflowHit(overflowHit), .pioActive(pioActive), .cmd(cmd)
  );

  rxdma_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inValid(inValid), .inData(inData),
    .inLast(inLast), .memWrAddr(memWrAddr), .headData(headData), .headLast(headLast),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .lastSlot(lastSlot),
    .overflowHit(overflowHit)
  );

  assign inReady    = cmd.acceptEn;
  assign memWrData  = headData;
  assign pioRdData  = headData;
  assign pioRdLast  = headLast;
  assign pioRdValid = pioActive && !fifoEmpty;
endmodule

// File: rtl/rxdma_checker.sv
module rxdma_checker (
  input logic        clk,
  input logic        rstN,
  input logic        enBit,
  input logic [31:0] statusWord,
  input logic        inReady,
  input logic        descRdReq,
  input logic        memWrEn,
  input logic        pioActive
);
  p_off_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> (statusWord == 32'h0));

  p_idle_stalls_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[15:12] == 4'd2) |-> (!inReady && !descRdReq));

  p_code_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[19:16] <= 4'd4) && (statusWord[15:12] <= 4'd3));

  p_write_when_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (statusWord[15:12] == 4'd1));

  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[15:12] == 4'd3) |-> (!inReady && !memWrEn && !descRdReq));

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[19:16] != 4'd0 && enBit) |=> $stable(statusWord[19:16]));

  p_pio_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    pioActive |-> (!memWrEn && !descRdReq));
endmodule

bind rx_ring_dma rxdma_checker u_chk (
  .clk(clk), .rstN(rstN), .enBit(rxCtrl[0]), .statusWord(statusWord),
  .inReady(inReady), .descRdReq(descRdReq), .memWrEn(memWrEn), .pioActive(pioActive)
);

// File: tb/rx_ring_dma_test.sv
module rx_ring_dma_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  rxCtrl = '0;
  logic [31:0] ringBase = 32'h0000_2000;
  logic [11:0] lastPtr = '0;
  logic [31:0] statusWord;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic        descRdReq;
  logic [31:0] descRdAddr;
  logic        descRdValid = 1'b0;
  logic [63:0] descRdData = '0;
  logic        descRdErr = 1'b0;
  logic        memWrEn;
  logic [31:0] memWrAddr;
  logic [7:0]  memWrData;
  logic        memWrErr;
  logic        pioRdEn = 1'b0;
  logic        pioRdValid;
  logic [7:0]  pioRdData;
  logic        pioRdLast;

  rx_ring_dma uut (.*);

  always #2 clk = ~clk;

  logic [63:0] descTab [4];
  logic        stallDesc = 1'b0;
  logic [31:0] logAddr [256];
  logic [7:0]  logData [256];
  int          logN = 0;
  int          reqCnt = 0;
  int          checks = 0;
  int          errors = 0;
  int          bufCnt [4] = '{8, 12, 16, 10};

  assign memWrErr = memWrEn && (memWrAddr[31:28] == 4'hF);

  always @(negedge clk) begin
    descRdValid <= descRdReq && !stallDesc;
    descRdData  <= descTab[descRdAddr[4:3]];
    descRdErr   <= descRdReq && (descRdAddr[31:28] == 4'hE);
    if (descRdReq) reqCnt = reqCnt + 1;
    if (memWrEn && logN < 256) begin
      logAddr[logN] = memWrAddr;
      logData[logN] = memWrData;
      logN = logN + 1;
    end
  end

  function automatic logic [63:0] mkDesc(input logic [31:0] a, input int cnt, input logic eot);
    return {a, 3'b000, eot, 15'b0, 13'(cnt)};
  endfunction

  function automatic logic [31:0] bufAddr(input int i);
    return 32'h0001_0000 + 32'(i) * 32'h100;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] d, input logic l, input int gap);
    @(negedge clk);
    inValid = 1'b1; inData = d; inLast = l;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    inValid = 1'b0; inLast = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic sendRaw(input int n, input logic l);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b1; inData = 8'(k); inLast = l;
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic restart(input logic [8:0] ctl, input logic [31:0] base, input logic [11:0] lp);
    @(negedge clk);
    rxCtrl = '0;
    idle(2);
    logN = 0; reqCnt = 0;
    ringBase = base; lastPtr = lp; rxCtrl = ctl;
  endtask

  task automatic stdRing();
    for (int i = 0; i < 4; i++) descTab[i] = mkDesc(bufAddr(i), bufCnt[i], i == 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int lens [5] = '{1, 2, 9, 20, 37};
    int offs [3] = '{0, 5, 7};
    stdRing();
    idle(3);
    rstN = 1'b1;
    idle(2);
    chk(statusWord == 32'h0, "R1 reset status", statusWord, 32'h0);
    chk(!inReady && !descRdReq && !memWrEn, "R1 reset quiet", {inReady, descRdReq, memWrEn}, 0);

    // R2 R3 R4 R6 R7: sweep of offsets and frame lengths over a four-entry ring
    foreach (offs[oi]) begin
      int mIdx;
      mIdx = 0;
      restart({1'b0, 7'(offs[oi]), 1'b1}, 32'h0000_2000, 12'h020);
      foreach (lens[li]) begin
        int pos, startIdx;
        bit newBuf, first, okBytes, okOff;
        logic [31:0] expA;
        logN = 0;
        for (int k = 0; k < lens[li]; k++)
          sendByte(8'(lens[li] * 7 + k + offs[oi]), k == lens[li] - 1, 2);
        idle(20);
        chk(logN == lens[li], "R4 write count", 32'(logN), 32'(lens[li]));
        startIdx = mIdx; newBuf = 1; first = 1; pos = 0;
        okBytes = 1; okOff = 1;
        for (int k = 0; k < lens[li]; k++) begin
          if (newBuf) begin
            pos = first ? offs[oi] : 0;
            newBuf = 0;
          end
          expA = bufAddr(mIdx) + 32'(pos);
          if (k < logN && (logAddr[k] != expA || logData[k] != 8'(lens[li] * 7 + k + offs[oi])))
            okBytes = 0;
          pos++;
          if (k == lens[li] - 1 || pos == bufCnt[mIdx]) begin
            mIdx = (mIdx == 3) ? 0 : mIdx + 1;
            newBuf = 1;
            first = 0;
          end
        end
        if (logN > 0 && logAddr[0] != bufAddr(startIdx) + 32'(offs[oi])) okOff = 0;
        chk(okOff, "R3 first byte at offset", logAddr[0], bufAddr(startIdx) + 32'(offs[oi]));
        chk(okBytes, "R4 R2 byte placement", 32'(lens[li]), 32'(offs[oi]));
        expA = {12'(mIdx * 8), 4'd0, 4'd1, 12'(mIdx * 8)};
        chk(statusWord == expA, "R2 R6 R7 status after frame", statusWord, expA);
      end
    end

    // R5: idle wait on the posted pointer
    restart(9'h001, 32'h0000_2000, 12'h000);
    idle(4);
    chk(statusWord == 32'h0000_2000, "R5 idle status", statusWord, 32'h0000_2000);
    chk(!inReady && reqCnt == 0, "R5 idle stalls", {inReady, 8'(reqCnt)}, 0);
    lastPtr = 12'h008;
    idle(4);
    chk(statusWord == 32'h0000_1000 && inReady, "R5 resume", statusWord, 32'h0000_1000);
    for (int k = 0; k < 3; k++) sendByte(8'hA0 + 8'(k), k == 2, 0);
    idle(8);
    chk(statusWord == 32'h0000_2008, "R5 R7 idle after frame", statusWord, 32'h0000_2008);
    chk(logN == 3 && logAddr[2] == bufAddr(0) + 2, "R3 zero offset", logAddr[2], bufAddr(0) + 2);

    // R8: byte count not above offset, then reserved control bit
    descTab[0] = mkDesc(bufAddr(0), 7, 1'b0);
    restart({1'b0, 7'd7, 1'b1}, 32'h0000_2000, 12'h020);
    idle(6);
    chk(statusWord == 32'h0001_3000, "R8 count vs offset", statusWord, 32'h0001_3000);
    sendRaw(3, 1'b1);
    idle(3);
    chk(logN == 0 && !inReady && statusWord == 32'h0001_3000, "R12 halted ignores data",
        statusWord, 32'h0001_3000);
    descTab[0] = mkDesc(bufAddr(0), 8, 1'b0) | 64'h4000_0000;
    restart(9'h001, 32'h0000_2000, 12'h020);
    idle(6);
    chk(statusWord == 32'h0001_3000, "R8 reserved bit", statusWord, 32'h0001_3000);

    // R9: descriptor bus error
    stdRing();
    restart(9'h001, 32'hE000_0000, 12'h020);
    idle(6);
    chk(statusWord == 32'h0004_3000, "R9 descriptor bus error", statusWord, 32'h0004_3000);

    // R1: disabling clears the error
    @(negedge clk); rxCtrl = '0;
    idle(2);
    chk(statusWord == 32'h0, "R1 disable clears", statusWord, 32'h0);

    // R10: write bus error stops after the failing write
    descTab[0] = mkDesc(32'hF000_0000, 8, 1'b0);
    restart(9'h001, 32'h0000_2000, 12'h020);
    idle(4);
    sendRaw(3, 1'b0);
    idle(6);
    chk(logN == 1, "R10 single write", 32'(logN), 1);
    chk(statusWord == 32'h0003_3000, "R10 status", statusWord, 32'h0003_3000);

    // R11: overflow while the descriptor read is stalled
    stdRing();
    stallDesc = 1'b1;
    restart(9'h001, 32'h0000_2000, 12'h020);
    sendRaw(12, 1'b0);
    idle(3);
    chk(statusWord == 32'h0002_3000 && logN == 0, "R11 overflow", statusWord, 32'h0002_3000);
    stallDesc = 1'b0;

    // R13: direct FIFO mode
    restart(9'h101, 32'h0000_2000, 12'h020);
    idle(2);
    for (int k = 0; k < 3; k++) sendByte(8'h50 + 8'(k), k == 2, 0);
    @(negedge clk); rxCtrl = 9'h001;
    idle(3);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(pioRdValid && pioRdData == 8'h50 + 8'(k) && pioRdLast == (k == 2), "R13 pio read",
          {pioRdValid, pioRdLast, pioRdData}, {1'b1, k == 2, 8'h50 + 8'(k)});
      pioRdEn = 1'b1;
      @(posedge clk); #1;
      pioRdEn = 1'b0;
    end
    @(negedge clk);
    chk(!pioRdValid && logN == 0 && reqCnt == 0, "R13 no traffic", {pioRdValid, 8'(logN), 8'(reqCnt)}, 0);
    for (int k = 0; k < 8; k++) sendByte(8'(k), 1'b0, 0);
    @(negedge clk);
    chk(!inReady && statusWord == 32'h0000_1000, "R13 backpressure", {inReady, statusWord}, 32'h0000_1000);
    chk(reqCnt == 0, "R13 mode change ignored", 32'(reqCnt), 0);

    finishRun();
  end
endmodule